// File: doc/BRIEF.md
# Memory Cycle Wait-State Generator

This block decides how long each processor memory cycle lasts when the memory behind it is either page-mode DRAM or static RAM. At the first clock of every cycle the processor presents a 2-bit cycle kind (non-sequential, sequential, internal or coprocessor) and the word address. The block answers in that same clock. It either completes the cycle at once, or it raises `wait_o` for one clock and completes in the next clock, which doubles the length of the cycle.

In DRAM mode, a non-sequential access always opens a new row, so it is stretched. A sequential access is stretched only when its word address is the first word of a row. With the default row size of four words, that is a byte address that is a multiple of 16. Internal and coprocessor cycles never touch memory and always end at once. Driving `sram_mode_i` high makes every cycle the minimum length. The block also counts sequential cycles that were stretched at a row boundary. This count is a measure of code alignment.

Top module: `mem_wait_gen`

## Requirements
- R1: After reset, `wait_o` and `done_o` are low and `s_stretch_cnt_o` is zero.
- R2: The cycle kind encoding is 00 = N, 01 = S, 10 = I, 11 = C. In DRAM mode (`sram_mode_i` = 0), an accepted N cycle raises `wait_o` (with `done_o` low) in its start clock and raises `done_o` (with `wait_o` low) in the next clock. This holds for any address.
- R3: In DRAM mode, an accepted S cycle whose word address has a nonzero value in bits [1:0] gives `done_o` high and `wait_o` low in its start clock.
- R4: In DRAM mode, an accepted S cycle whose word address has bits [1:0] = 00 is stretched exactly like an N cycle.
- R5: I (10) and C (11) cycles give `done_o` in their start clock with no wait, whatever the address or mode.
- R6: With `sram_mode_i` = 1, every cycle kind gives `done_o` in its start clock and `wait_o` never rises.
- R7: A `start_i` presented in the second clock of a stretched cycle is ignored. In that clock `done_o` is high and `wait_o` is low. In the following clock `done_o` is low, and the counter is unchanged.
- R8: `s_stretch_cnt_o` rises by one, one clock after each accepted S cycle that was stretched. N, I and C cycles, unstretched S cycles and SRAM-mode cycles leave it unchanged. It wraps modulo 2^16.
- R9: `wait_o` and `done_o` are never high in the same clock, and `done_o` is low in any clock with no start and no pending stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | First clock of a new memory cycle |
| kind_i | input | 2 | Cycle kind: 00 N, 01 S, 10 I, 11 C |
| word_addr_i | input | 30 | Word address of the cycle |
| sram_mode_i | input | 1 | 1 = static RAM timing, 0 = page-mode DRAM timing |
| wait_o | output | 1 | Cycle is stretched by one clock |
| done_o | output | 1 | Final clock of the current cycle |
| s_stretch_cnt_o | output | 16 | Count of S cycles stretched at a row start |

## Verification
Each cycle kind is driven in DRAM mode at a row-start address and at an address in the middle of a row. This separates the kind-driven decision from the address-driven one: N must stretch at both addresses, S only at the row start, and I and C at neither. The same patterns are repeated with SRAM mode on, to show that the mode overrides both factors. A back-to-back start placed in the completion clock of a stretched cycle checks that the pending state cannot be retriggered. The counter is read after each pattern to tell stretched S cycles apart from every other stretched or unstretched cycle.

// File: rtl/mem_wait_pkg.sv
package mem_wait_pkg;
  typedef enum logic [1:0] {
    CYC_N = 2'b00,
    CYC_S = 2'b01,
    CYC_I = 2'b10,
    CYC_C = 2'b11
  } cyc_kind_t;
endpackage

// File: rtl/stretch_judge.sv
module stretch_judge
  import mem_wait_pkg::*;
#(
  parameter int ADDR_W   = 30,
  parameter int ROW_LOG2 = 2
) (
  input  cyc_kind_t          kind_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               sram_i,
  output logic               stretch_o,
  output logic               s_row_o
);
  logic row_start;

  always_comb begin
    row_start = (addr_i[ROW_LOG2-1:0] == '0);
    s_row_o   = !sram_i && (kind_i == CYC_S) && row_start;
    stretch_o = !sram_i && ((kind_i == CYC_N) || s_row_o);
  end

  // R5: internal and coprocessor cycles never stretch
  always_comb begin
    if (kind_i == CYC_I || kind_i == CYC_C)
      a_r5_ic_short: assert (!stretch_o);
  end
endmodule

// File: rtl/cyc_seq.sv
module cyc_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stretch_i,
  output logic accept_o,
  output logic wait_o,
  output logic done_o
);
  logic pend_q, pend_d;

  always_comb begin
    accept_o = start_i && !pend_q;
    wait_o   = accept_o && stretch_i;
    done_o   = pend_q || (accept_o && !stretch_i);
    pend_d   = wait_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_o && done_o));
  a_r2_done_follows_wait: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |=> done_o);
  a_r7_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |=> !wait_o);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !pend_q) |-> !done_o);
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> (cnt_o == $past(cnt_o) + 1'b1));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/mem_wait_gen.sv
module mem_wait_gen
  import mem_wait_pkg::*;
#(
  parameter int ADDR_W   = 30,
  parameter int ROW_LOG2 = 2,
  parameter int CNT_W    = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] word_addr_i,
  input  logic              sram_mode_i,
  output logic              wait_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  s_stretch_cnt_o
);
  logic [SYNC_LEN-1:0] rst_pipe_q;
  logic rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[SYNC_LEN-1];

  cyc_kind_t kind;
  logic stretch, s_row, accept;

  assign kind = cyc_kind_t'(kind_i);

  stretch_judge #(.ADDR_W(ADDR_W), .ROW_LOG2(ROW_LOG2)) u_judge (
    .kind_i    (kind),
    .addr_i    (word_addr_i),
    .sram_i    (sram_mode_i),
    .stretch_o (stretch),
    .s_row_o   (s_row)
  );

  cyc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start_i   (start_i),
    .stretch_i (stretch),
    .accept_o  (accept),
    .wait_o    (wait_o),
    .done_o    (done_o)
  );

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_int),
    .inc_i (accept && s_row),
    .cnt_o (s_stretch_cnt_o)
  );

  a_r6_sram_nowait: assert property (@(posedge clk) disable iff (!rst_n_int)
    sram_mode_i |-> !wait_o);
  a_r2_n_stretch: assert property (@(posedge clk) disable iff (!rst_n_int)
    (accept && !sram_mode_i && kind_i == 2'b00) |-> (wait_o && !done_o));
  a_r3_s_midrow: assert property (@(posedge clk) disable iff (!rst_n_int)
    (accept && !sram_mode_i && kind_i == 2'b01 && word_addr_i[ROW_LOG2-1:0] != '0)
      |-> (done_o && !wait_o));
endmodule

// File: tb/tb_mem_wait_gen.sv
module tb_mem_wait_gen;
  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0] kind;
  logic [29:0] addr;
  logic sram;
  logic wt, dn;
  logic [15:0] cnt;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mem_wait_gen dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind),
    .word_addr_i(addr), .sram_mode_i(sram), .wait_o(wt), .done_o(dn),
    .s_stretch_cnt_o(cnt)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cycle(input string req, input logic [1:0] k, input logic [29:0] a,
                           input logic sm, input bit exp_str, input bit exp_inc);
    logic [15:0] c0;
    @(negedge clk);
    c0 = cnt;
    start = 1'b1; kind = k; addr = a; sram = sm;
    #2;
    chk(req, {14'd0, wt, dn}, exp_str ? 16'd2 : 16'd1);
    @(negedge clk);
    start = 1'b0;
    #2;
    chk(req, {14'd0, wt, dn}, exp_str ? 16'd1 : 16'd0);
    @(negedge clk);
    chk(req, cnt, c0 + (exp_inc ? 16'd1 : 16'd0));
  endtask

  task automatic t_reset;
    chk("R1", {14'd0, wt, dn}, 16'd0);
    chk("R1", cnt, 16'd0);
  endtask

  task automatic t_dram;
    run_cycle("R2", 2'b00, 30'h0000_0005, 1'b0, 1'b1, 1'b0);
    run_cycle("R2", 2'b00, 30'h0000_0008, 1'b0, 1'b1, 1'b0);
    run_cycle("R3", 2'b01, 30'h0000_0003, 1'b0, 1'b0, 1'b0);
    run_cycle("R3", 2'b01, 30'h0000_0001, 1'b0, 1'b0, 1'b0);
    run_cycle("R4", 2'b01, 30'h0000_0004, 1'b0, 1'b1, 1'b1);
    run_cycle("R4", 2'b01, 30'h3FFF_FFFC, 1'b0, 1'b1, 1'b1);
    run_cycle("R5", 2'b10, 30'h0000_0000, 1'b0, 1'b0, 1'b0);
    run_cycle("R5", 2'b11, 30'h0000_0010, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sram;
    for (int k = 0; k < 4; k++)
      run_cycle("R6", 2'(k), 30'h0000_0000, 1'b1, 1'b0, 1'b0);
    run_cycle("R6", 2'b00, 30'h0000_0007, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_retrigger;
    logic [15:0] c0;
    @(negedge clk);
    c0 = cnt;
    start = 1'b1; kind = 2'b00; addr = 30'd2; sram = 1'b0;
    #2;
    chk("R7", {14'd0, wt, dn}, 16'd2);
    @(negedge clk);
    kind = 2'b01; addr = 30'd0;
    #2;
    chk("R7", {14'd0, wt, dn}, 16'd1);
    @(negedge clk);
    start = 1'b0;
    #2;
    chk("R7", {14'd0, wt, dn}, 16'd0);
    chk("R7", cnt, c0);
  endtask

  task automatic t_count_run;
    logic [15:0] c0;
    @(negedge clk);
    c0 = cnt;
    for (int i = 0; i < 5; i++) begin
      run_cycle("R8", 2'b01, 30'(i * 4), 1'b0, 1'b1, 1'b1);
      run_cycle("R8", 2'b01, 30'(i * 4 + 1), 1'b0, 1'b0, 1'b0);
    end
    chk("R8", cnt, c0 + 16'd5);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; kind = 2'b00; addr = '0; sram = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_dram();
    t_sram();
    t_retrigger();
    t_count_run();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule